// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block carries inter-processor interrupts between up to eight CPUs. A CPU raises one by writing a single command word. The word holds an interrupt number, a filter mode and an optional list of target CPUs. The block turns that write into pending bits, one per target CPU, per software interrupt number and per requesting CPU. Each CPU then sees one level-sensitive request line.

Each CPU services its request through three accesses on a simple register bus:
- An acknowledge read returns the chosen interrupt together with the number of the CPU that sent it, and marks that interrupt active.
- An end-of-interrupt write returns the acknowledged value and retires it.
- An active-clear write drops the active state of any interrupt selected by a bit mask, without an end-of-interrupt.

Selection is fixed: the lowest interrupt number goes first, then the lowest requester. While a CPU has any interrupt active, its request line stays low and its acknowledge reads return the spurious number.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset nothing is pending or active, every `irq` bit is 0, and an acknowledge read returns 1023.
- R2: A command word with bits 25:24 = 2 makes the interrupt pending only on the requesting CPU (`sgi_wr_cpu`).
- R3: A command word with bits 25:24 = 1 makes the interrupt pending on every implemented CPU except the requester.
- R4: With bits 25:24 = 0, the targets are the CPUs whose bits are set in bits 23:16 (bit 16 is CPU 0). Bits for CPU numbers at or above NCPU are ignored. With bits 25:24 = 3 the write has no effect.
- R5: The interrupt number sits in command bits 9:0, and a number of NSGI or more is ignored. An acknowledge word carries the number in bits 9:0, the requester in bits 12:10, and zeros above.
- R6: When several interrupts are deliverable to a CPU, acknowledge picks the lowest number. For that number it picks the lowest requester.
- R7: Acknowledge moves the chosen interrupt from pending to active. While any interrupt is active on a CPU, that CPU's `irq` is 0. An interrupt written again while active becomes pending and is delivered once it has left the active state.
- R8: If a CPU has nothing deliverable, its acknowledge read returns 1023 and changes no state.
- R9: An end-of-interrupt write clears the active state of the number in its bits 9:0 on the writing CPU. Numbers of NSGI or more (such as 1023) are ignored.
- R10: An active-clear write with bit n set clears the active state of interrupt n on the writing CPU. Bits for inactive interrupts have no effect.
- R11: Pending state is held per requester: the same number sent by two CPUs is acknowledged twice, once with each requester number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sgi_wr_en | input | 1 | Command write strobe |
| sgi_wr_cpu | input | 3 | Number of the requesting CPU |
| sgi_wr_data | input | 32 | Command word: number, target list, filter mode |
| ack_rd_en | input | 1 | Acknowledge read strobe; state changes at the clock edge |
| ack_rd_cpu | input | 3 | CPU performing the acknowledge |
| ack_rd_data | output | 32 | Acknowledge word, combinational in the strobe cycle |
| eoi_wr_en | input | 1 | End-of-interrupt write strobe |
| eoi_wr_cpu | input | 3 | CPU performing the end-of-interrupt |
| eoi_wr_data | input | 32 | Value previously acknowledged |
| aclr_wr_en | input | 1 | Active-clear write strobe |
| aclr_wr_cpu | input | 3 | CPU performing the active clear |
| aclr_wr_data | input | 32 | One bit per interrupt number to deactivate |
| irq | output | NCPU | Interrupt request, one bit per CPU |

## Verification
The properties assume that a requesting CPU number is always below NCPU. They also assume that each of the three CPU-side ports carries at most one access per cycle, for the CPU named alongside it. The stimulus draws every CPU index from the implemented range, and it issues one bus operation per cycle, so the assumptions always hold. Out-of-range interrupt numbers, unimplemented target-list bits and the reserved filter code are driven on purpose, because the design must absorb them.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int CPU_FW   = 3;
   localparam int ID_FW    = 10;
   localparam int LIST_LSB = 16;
   localparam int FILT_LSB = 24;
   localparam logic [ID_FW-1:0] SPURIOUS = 10'd1023;

   typedef enum logic [1:0] {
      FILT_LIST   = 2'd0,
      FILT_OTHERS = 2'd1,
      FILT_SELF   = 2'd2,
      FILT_NONE   = 2'd3
   } filt_e;

   function automatic logic [31:0] pack_ack(input logic [CPU_FW-1:0] src,
                                            input logic [ID_FW-1:0]  id);
      return {19'd0, src, id};
   endfunction
endpackage

// File: rtl/sgi_write_decode.sv
module sgi_write_decode
   import sgi_pkg::*;
#(
   parameter int NCPU = 8,
   parameter int NSGI = 16
) (
   input  logic              wr_en,
   input  logic [CPU_FW-1:0] req_cpu,
   input  logic [31:0]       wr_word,
   output logic [NCPU-1:0]   tgt_mask,
   output logic [3:0]        sgi_id
);
   logic [ID_FW-1:0] raw_id;
   filt_e            filt;
   logic [NCPU-1:0]  self_oh;
   logic [NCPU-1:0]  list_bits;
   logic             id_ok;
   logic             req_ok;
   logic             unused_word;

   assign unused_word = ^wr_word;
   assign raw_id      = wr_word[ID_FW-1:0];
   assign filt        = filt_e'(wr_word[FILT_LSB +: 2]);
   assign list_bits   = wr_word[LIST_LSB +: NCPU];
   assign id_ok       = 32'(raw_id) < NSGI;
   assign req_ok      = 32'(req_cpu) < NCPU;
   assign sgi_id      = raw_id[3:0];

   always_comb begin
      for (int c = 0; c < NCPU; c++) self_oh[c] = (32'(req_cpu) == c);
   end

   always_comb begin
      tgt_mask = '0;
      if (wr_en && id_ok && req_ok) begin
         unique case (filt)
            FILT_LIST:   tgt_mask = list_bits;
            FILT_OTHERS: tgt_mask = ~self_oh;
            FILT_SELF:   tgt_mask = self_oh;
            FILT_NONE:   tgt_mask = '0;
            default:     tgt_mask = '0;
         endcase
      end
   end
endmodule

// File: rtl/sgi_cpu_slice.sv
module sgi_cpu_slice
   import sgi_pkg::*;
#(
   parameter int NCPU = 8,
   parameter int NSGI = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [3:0]        set_id,
   input  logic [CPU_FW-1:0] set_src,
   input  logic              ack_en,
   input  logic              eoi_en,
   input  logic [ID_FW-1:0]  eoi_id,
   input  logic              aclr_en,
   input  logic [NSGI-1:0]   aclr_mask,
   output logic              irq,
   output logic [31:0]       ack_word
);
   logic [NCPU-1:0]   pend_q [NSGI];
   logic [NCPU-1:0]   pend_n [NSGI];
   logic [NSGI-1:0]   act_q, act_n;
   logic              hit;
   logic [3:0]        sel_id;
   logic [CPU_FW-1:0] sel_src;

   // lowest number first, then lowest requester: the descending scan lets the
   // smallest qualifying index overwrite the earlier ones
   always_comb begin
      hit     = 1'b0;
      sel_id  = '0;
      sel_src = '0;
      for (int i = NSGI - 1; i >= 0; i--) begin
         if ((|pend_q[i]) && !act_q[i]) begin
            hit    = 1'b1;
            sel_id = 4'(i);
            for (int s = NCPU - 1; s >= 0; s--)
               if (pend_q[i][s]) sel_src = CPU_FW'(s);
         end
      end
   end

   assign irq      = hit && (act_q == '0);
   assign ack_word = irq ? pack_ack(sel_src, ID_FW'(sel_id)) : pack_ack('0, SPURIOUS);

   always_comb begin
      pend_n = pend_q;
      act_n  = act_q;
      for (int i = 0; i < NSGI; i++)
         if (eoi_en && (32'(eoi_id) == i)) act_n[i] = 1'b0;
      if (aclr_en) act_n = act_n & ~aclr_mask;
      if (ack_en && irq) begin
         for (int i = 0; i < NSGI; i++) begin
            if (sel_id == 4'(i)) begin
               act_n[i] = 1'b1;
               for (int s = 0; s < NCPU; s++)
                  if (sel_src == CPU_FW'(s)) pend_n[i][s] = 1'b0;
            end
         end
      end
      if (set_en) begin
         for (int i = 0; i < NSGI; i++)
            for (int s = 0; s < NCPU; s++)
               if ((set_id == 4'(i)) && (set_src == CPU_FW'(s))) pend_n[i][s] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '{default: '0};
         act_q  <= '0;
      end else begin
         pend_q <= pend_n;
         act_q  <= act_n;
      end
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int NCPU = 8,
   parameter int NSGI = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sgi_wr_en,
   input  logic [2:0]      sgi_wr_cpu,
   input  logic [31:0]     sgi_wr_data,
   input  logic            ack_rd_en,
   input  logic [2:0]      ack_rd_cpu,
   output logic [31:0]     ack_rd_data,
   input  logic            eoi_wr_en,
   input  logic [2:0]      eoi_wr_cpu,
   input  logic [31:0]     eoi_wr_data,
   input  logic            aclr_wr_en,
   input  logic [2:0]      aclr_wr_cpu,
   input  logic [31:0]     aclr_wr_data,
   output logic [NCPU-1:0] irq
);
   generate
      if (NCPU < 1 || NCPU > 8) begin : g_bad_ncpu
         $error("sgi_dispatch: NCPU must lie in 1..8");
      end
      if (NSGI < 2 || NSGI > 16) begin : g_bad_nsgi
         $error("sgi_dispatch: NSGI must lie in 2..16");
      end
   endgenerate

   logic [NCPU-1:0] tgt_mask;
   logic [3:0]      set_id;
   logic [31:0]     slice_word [NCPU];
   logic            unused_bus;

   assign unused_bus = ^{eoi_wr_data[31:ID_FW], aclr_wr_data};

   sgi_write_decode #(.NCPU(NCPU), .NSGI(NSGI)) dec_i (
      .wr_en    (sgi_wr_en),
      .req_cpu  (sgi_wr_cpu),
      .wr_word  (sgi_wr_data),
      .tgt_mask (tgt_mask),
      .sgi_id   (set_id)
   );

   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
         sgi_cpu_slice #(.NCPU(NCPU), .NSGI(NSGI)) slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en    (tgt_mask[c]),
            .set_id    (set_id),
            .set_src   (sgi_wr_cpu),
            .ack_en    (ack_rd_en  && (ack_rd_cpu  == 3'(c))),
            .eoi_en    (eoi_wr_en  && (eoi_wr_cpu  == 3'(c))),
            .eoi_id    (eoi_wr_data[ID_FW-1:0]),
            .aclr_en   (aclr_wr_en && (aclr_wr_cpu == 3'(c))),
            .aclr_mask (aclr_wr_data[NSGI-1:0]),
            .irq       (irq[c]),
            .ack_word  (slice_word[c])
         );
      end
   endgenerate

   always_comb begin
      ack_rd_data = pack_ack('0, SPURIOUS);
      for (int c = 0; c < NCPU; c++)
         if (ack_rd_cpu == 3'(c)) ack_rd_data = slice_word[c];
   end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
   parameter int NCPU = 8,
   parameter int NSGI = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NCPU-1:0] irq,
   input logic            ack_rd_en,
   input logic [2:0]      ack_rd_cpu,
   input logic [31:0]     ack_rd_data,
   input logic            sgi_wr_en,
   input logic [2:0]      sgi_wr_cpu,
   input logic            eoi_wr_en,
   input logic            aclr_wr_en
);
   p_idle_in_reset_r1: assert property (@(posedge clk) !rst_n |-> (irq == '0));

   p_req_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sgi_wr_en |-> (32'(sgi_wr_cpu) < NCPU));

   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
         p_ack_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd_en && (ack_rd_cpu == 3'(c)) && irq[c]) |->
            ((32'(ack_rd_data[9:0]) < NSGI) && (32'(ack_rd_data[12:10]) < NCPU) &&
             (ack_rd_data[31:13] == '0)));

         p_irq_drop_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd_en && (ack_rd_cpu == 3'(c)) && irq[c]) |=> !irq[c]);

         p_spurious_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd_en && (ack_rd_cpu == 3'(c)) && !irq[c]) |-> (ack_rd_data == 32'd1023));

         p_irq_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(sgi_wr_en || eoi_wr_en || aclr_wr_en));
      end
   endgenerate
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq         (irq),
   .ack_rd_en   (ack_rd_en),
   .ack_rd_cpu  (ack_rd_cpu),
   .ack_rd_data (ack_rd_data),
   .sgi_wr_en   (sgi_wr_en),
   .sgi_wr_cpu  (sgi_wr_cpu),
   .eoi_wr_en   (eoi_wr_en),
   .aclr_wr_en  (aclr_wr_en)
);

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
   localparam int NC = 6;
   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sgi_wr_en = 1'b0;
   logic [2:0]    sgi_wr_cpu = '0;
   logic [31:0]   sgi_wr_data = '0;
   logic          ack_rd_en = 1'b0;
   logic [2:0]    ack_rd_cpu = '0;
   logic [31:0]   ack_rd_data;
   logic          eoi_wr_en = 1'b0;
   logic [2:0]    eoi_wr_cpu = '0;
   logic [31:0]   eoi_wr_data = '0;
   logic          aclr_wr_en = 1'b0;
   logic [2:0]    aclr_wr_cpu = '0;
   logic [31:0]   aclr_wr_data = '0;
   logic [NC-1:0] irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit m_pend [NC][NS][NC];
   bit m_act  [NC][NS];
   logic [31:0] last_ack [NC];

   always #2 clk = ~clk;

   sgi_dispatch #(.NCPU(NC), .NSGI(NS)) dut_i (.*);

   function automatic logic [31:0] exp_ack(int c);
      for (int i = 0; i < NS; i++) if (m_act[c][i]) return 32'd1023;
      for (int i = 0; i < NS; i++)
         for (int s = 0; s < NC; s++)
            if (m_pend[c][i][s]) return 32'((s << 10) | i);
      return 32'd1023;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic chk_irqs(input string req);
      for (int c = 0; c < NC; c++)
         chk(irq[c] == (exp_ack(c) != 32'd1023), req, $sformatf("irq[%0d]", c),
             longint'(irq[c]), longint'(exp_ack(c) != 32'd1023));
   endtask

   task automatic sgi(input int req, input int filt, input int tgts, input int id,
                      input string tag);
      @(negedge clk);
      sgi_wr_en   = 1'b1;
      sgi_wr_cpu  = 3'(req);
      sgi_wr_data = 32'((filt << 24) | ((tgts & 255) << 16) | (id & 1023));
      @(posedge clk);
      #1 sgi_wr_en = 1'b0;
      if (id < NS) begin
         for (int t = 0; t < NC; t++) begin
            bit hit;
            case (filt)
               0: hit = ((tgts >> t) & 1) != 0;
               1: hit = (t != req);
               2: hit = (t == req);
               default: hit = 1'b0;
            endcase
            if (hit) m_pend[t][id][req] = 1'b1;
         end
      end
      chk_irqs(tag);
   endtask

   task automatic ack(input int c, input string tag);
      logic [31:0] e;
      @(negedge clk);
      ack_rd_en  = 1'b1;
      ack_rd_cpu = 3'(c);
      #1;
      e = exp_ack(c);
      chk(ack_rd_data == e, tag, $sformatf("ack cpu%0d", c), longint'(ack_rd_data), longint'(e));
      @(posedge clk);
      #1 ack_rd_en = 1'b0;
      if (e != 32'd1023) begin
         m_pend[c][e[9:0]][e[12:10]] = 1'b0;
         m_act[c][e[9:0]] = 1'b1;
         last_ack[c] = e;
      end
      chk_irqs(tag);
   endtask

   task automatic eoi(input int c, input logic [31:0] d, input string tag);
      @(negedge clk);
      eoi_wr_en   = 1'b1;
      eoi_wr_cpu  = 3'(c);
      eoi_wr_data = d;
      @(posedge clk);
      #1 eoi_wr_en = 1'b0;
      if (d[9:0] < NS) m_act[c][d[9:0]] = 1'b0;
      chk_irqs(tag);
   endtask

   task automatic aclr(input int c, input logic [31:0] m, input string tag);
      @(negedge clk);
      aclr_wr_en   = 1'b1;
      aclr_wr_cpu  = 3'(c);
      aclr_wr_data = m;
      @(posedge clk);
      #1 aclr_wr_en = 1'b0;
      for (int i = 0; i < NS; i++) if (m[i]) m_act[c][i] = 1'b0;
      chk_irqs(tag);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1: got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         last_ack[c] = 32'd1023;
         for (int i = 0; i < NS; i++) begin
            m_act[c][i] = 1'b0;
            for (int s = 0; s < NC; s++) m_pend[c][i][s] = 1'b0;
         end
      end
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      #1;
      chk(irq == '0, "R1", "irq in reset", longint'(irq), 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 chk_irqs("R1");
      for (int c = 0; c < NC; c++) ack(c, "R1");

      // self only, ack word layout, spurious after ack, end of interrupt
      sgi(2, 2, 0, 5, "R2");
      ack(2, "R5");
      chk(last_ack[2] == 32'h805, "R5", "ack word", longint'(last_ack[2]), 32'h805);
      ack(2, "R8");
      eoi(2, 32'h805, "R9");
      ack(0, "R8");

      // everyone except the requester
      sgi(1, 1, 0, 3, "R3");
      for (int c = 0; c < NC; c++) ack(c, "R3");
      for (int c = 0; c < NC; c++) eoi(c, last_ack[c], "R9");

      // explicit list with bits for absent CPUs 6 and 7, then reserved filter
      sgi(4, 0, 8'hC5, 1, "R4");
      sgi(4, 3, 8'hFF, 2, "R4");
      for (int c = 0; c < NC; c++) ack(c, "R4");
      for (int c = 0; c < NC; c++) eoi(c, last_ack[c], "R9");

      // out-of-range interrupt number ignored
      sgi(0, 2, 0, 20, "R5");
      ack(0, "R5");

      // ordering by number then requester, and per-requester pending
      sgi(3, 0, 8'h01, 7, "R11");
      sgi(1, 0, 8'h01, 7, "R11");
      sgi(5, 0, 8'h01, 4, "R6");
      ack(0, "R6");
      eoi(0, last_ack[0], "R6");
      ack(0, "R11");
      eoi(0, last_ack[0], "R11");
      ack(0, "R11");
      eoi(0, last_ack[0], "R11");

      // re-pend while active, end of interrupt with ignored number
      sgi(3, 2, 0, 9, "R7");
      ack(3, "R7");
      sgi(3, 2, 0, 9, "R7");
      eoi(3, 32'd1023, "R9");
      ack(3, "R7");
      eoi(3, 32'd9 | (32'd3 << 10), "R7");
      ack(3, "R7");

      // active clear: bits for inactive numbers, then the active one
      sgi(2, 0, 8'h08, 0, "R10");
      aclr(3, 32'h0000_FDFF, "R10");
      aclr(3, 32'h0000_0200, "R10");
      ack(3, "R10");
      aclr(3, 32'h0000_0001, "R10");
      ack(3, "R8");

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int op;
         int c;
         op = int'($urandom % 10);
         c  = int'($urandom % NC);
         if (op < 4)
            sgi(c, int'($urandom % 4), int'($urandom % 256), int'($urandom % 20), "R6");
         else if (op < 7)
            ack(c, "R6");
         else if (op < 9)
            eoi(c, ($urandom % 4 != 0) ? last_ack[c] : 32'($urandom % 18), "R9");
         else
            aclr(c, 32'(1) << ($urandom % 16), "R10");
      end
      finish_run();
   end
endmodule